// File: doc/BRIEF.md
# Round-Robin Monitor Sequencer

This block runs a hardware monitoring loop over nine measurement slots. In each slot it asks an external converter for one result. It stores the result in a value RAM and checks it against a programmed high and low limit. Any violation sets a sticky status flag, and an active-low interrupt line reports those flags after per-source masking and a global enable. Between two loops the block idles for a parameterised number of cycles, which sets the loop period.

The converter is abstracted as two valid/ready channels. On the request channel the block presents a slot index and waits for `conv_req_ready`. On the response channel it raises `conv_rsp_ready` only while it waits for that one result. The block never has more than one request outstanding. A converter may stall either channel for any number of cycles. The host supplies the run, interrupt-enable and interrupt-clear control bits as plain levels. It loads limits through a write strobe and reads stored results combinationally by slot index. A one-cycle `stat_clr` pulse models the clearing read of the status flags.

Slot order: 0 temperature, 1 auxiliary processor rail or negative rail, 2 +12 V, 3 +5 V, 4 +3.3 V, 5 +2.5 V, 6 processor core rail, 7 fan 1, 8 fan 2.

Top module: `rr_monitor`

## Requirements
- R1: While running, requests are issued for slots 0 to 8 in ascending order. After slot 8's result is accepted, exactly LOOP_CYCLES idle cycles pass with `conv_req_valid` low before the slot 0 request of the next loop.
- R2: Each accepted result is written into the value RAM at its slot and appears on `val_rd_data` when `val_rd_slot` selects that slot.
- R3: Once raised, `conv_req_valid` stays high with `conv_req_slot` unchanged until `conv_req_ready` is seen. `conv_rsp_ready` is high only while no request is pending, and only one request is outstanding at a time.
- R4: Slot 0 is compared as signed two's complement. Its flag (bit 0) sets when the result is above the high limit or below the low limit, so 0xE7 (-25) passes against limits -40..25 and 0xD0 (-48) fails.
- R5: Slots 1 to 6 are compared unsigned. Flag bit n sets when the result is above the high limit or below the low limit.
- R6: Slots 7 and 8 hold fan counts. Their flag sets only when the count is above the high limit. A count below the low limit raises no flag.
- R7: Status flags are sticky across loops. A `stat_clr` pulse clears all flags; a violation in the same cycle still sets its flag.
- R8: `irq_n` is low exactly when `cfg_int_en` is 1, `cfg_int_clr` is 0, and some flag is set whose `irq_mask` bit is 0. A mask bit of 1 suppresses that source.
- R9: Monitoring runs while `cfg_start` is 1 and `cfg_int_clr` is 0. When either condition drops, the loop in progress completes through slot 8, then `mon_active` goes low and no further requests issue.
- R10: Every start from the halted state begins at slot 0.
- R11: Setting `cfg_int_clr` forces `irq_n` high and leaves the status flags unchanged.
- R12: After reset, `irq_n` is 1, `conv_req_valid` is 0, `mon_active` is 0, and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 1 | Run request |
| cfg_int_en | input | 1 | Global interrupt output enable |
| cfg_int_clr | input | 1 | Interrupt clear; also halts monitoring |
| irq_mask | input | 9 | Per-source mask, 1 suppresses |
| conv_req_valid | output | 1 | Conversion request valid |
| conv_req_ready | input | 1 | Converter accepts request |
| conv_req_slot | output | 4 | Slot being requested |
| conv_rsp_valid | input | 1 | Conversion result valid |
| conv_rsp_ready | output | 1 | Block accepts result |
| conv_rsp_data | input | 8 | Conversion result |
| lim_wr_en | input | 1 | Limit write strobe |
| lim_wr_slot | input | 4 | Slot whose limits are written |
| lim_wr_hi | input | 8 | High limit value |
| lim_wr_lo | input | 8 | Low limit value |
| val_rd_slot | input | 4 | Value RAM read index |
| val_rd_data | output | 8 | Stored result for that slot |
| stat_flags | output | 9 | Sticky violation flags, bit n = slot n |
| stat_clr | input | 1 | Clear all flags (models clearing read) |
| mon_active | output | 1 | High while the sequencer is not halted |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with LOOP_CYCLES set to 20 and keeps the default 8-bit data width. The short gap lets it count the idle window between loops exactly and run several complete loops. Across those loops it covers signed and unsigned limit violations, fan low counts that must be ignored, and a stop mid-loop or a clear-driven halt followed by a restart. The converter model stalls both channels for lengths that depend on the slot, so the hold rules and the single-outstanding-request rule are exercised.

// File: rtl/rrm_pkg.sv
package rrm_pkg;

  localparam int NUM_SLOTS = 9;
  localparam int SLOT_W    = 4;
  localparam int FAN_BASE  = 7;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_RSP  = 2'd2,
    SQ_GAP  = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    CMP_SIGNED = 2'd0,
    CMP_RANGE  = 2'd1,
    CMP_FAN    = 2'd2
  } cmp_kind_e;

  function automatic cmp_kind_e slot_kind(int idx);
    if (idx == 0)             return CMP_SIGNED;
    else if (idx < FAN_BASE)  return CMP_RANGE;
    else                      return CMP_FAN;
  endfunction

endpackage

// File: rtl/rrm_sequencer.sv
module rrm_sequencer
  import rrm_pkg::*;
#(
  parameter int LOOP_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [SLOT_W-1:0] req_slot,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  output logic              rsp_take,
  output logic              active
);

  localparam int GAP_W = $clog2(LOOP_CYCLES + 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
  localparam logic [GAP_W-1:0]  GAP_END   = GAP_W'(LOOP_CYCLES - 1);

  seq_state_e        state;
  logic [SLOT_W-1:0] slot;
  logic [GAP_W-1:0]  gap_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      slot    <= '0;
      gap_cnt <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          slot <= '0;
          if (run) state <= SQ_REQ;
        end
        SQ_REQ: begin
          if (req_ready) state <= SQ_RSP;
        end
        SQ_RSP: begin
          if (rsp_valid) begin
            if (slot == LAST_SLOT) begin
              slot    <= '0;
              gap_cnt <= '0;
              state   <= run ? SQ_GAP : SQ_IDLE;
            end else begin
              slot  <= slot + 1'b1;
              state <= SQ_REQ;
            end
          end
        end
        SQ_GAP: begin
          if (!run)                  state <= SQ_IDLE;
          else if (gap_cnt == GAP_END) state <= SQ_REQ;
          else                       gap_cnt <= gap_cnt + 1'b1;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign req_valid = (state == SQ_REQ);
  assign req_slot  = slot;
  assign rsp_ready = (state == SQ_RSP);
  assign rsp_take  = rsp_ready && rsp_valid;
  assign active    = (state != SQ_IDLE);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_slot)); // R3

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready)); // R3

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_slot <= LAST_SLOT); // R1

  AST_RESTART_TEMP: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !req_valid || req_slot == '0); // R10

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active && !run |=> !req_valid); // R9

endmodule

// File: rtl/rrm_store.sv
module rrm_store
  import rrm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lim_we,
  input  logic [SLOT_W-1:0] lim_slot,
  input  logic [DATA_W-1:0] lim_hi,
  input  logic [DATA_W-1:0] lim_lo,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_viol
);

  logic [DATA_W-1:0]    val_mem [NUM_SLOTS];
  logic [DATA_W-1:0]    hi_mem  [NUM_SLOTS];
  logic [DATA_W-1:0]    lo_mem  [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] viol_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        val_mem[i] <= '0;
        hi_mem[i]  <= '0;
        lo_mem[i]  <= '0;
      end
    end else begin
      if (lim_we && (int'(lim_slot) < NUM_SLOTS)) begin
        hi_mem[lim_slot] <= lim_hi;
        lo_mem[lim_slot] <= lim_lo;
      end
      if (wr_en && (int'(wr_slot) < NUM_SLOTS))
        val_mem[wr_slot] <= wr_data;
    end
  end

  // One comparator per slot; the slot kind picks signed, windowed or fan-only.
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
    if (slot_kind(g) == CMP_SIGNED) begin : g_signed
      assign viol_vec[g] = ($signed(wr_data) > $signed(hi_mem[g])) ||
                           ($signed(wr_data) < $signed(lo_mem[g]));
    end else if (slot_kind(g) == CMP_RANGE) begin : g_range
      assign viol_vec[g] = (wr_data > hi_mem[g]) || (wr_data < lo_mem[g]);
    end else begin : g_fan
      assign viol_vec[g] = (wr_data > hi_mem[g]);
    end
  end

  assign wr_viol = (int'(wr_slot) < NUM_SLOTS) ? viol_vec[wr_slot] : 1'b0;
  assign rd_data = (int'(rd_slot) < NUM_SLOTS) ? val_mem[rd_slot] : '0;

endmodule

// File: rtl/rrm_irq.sv
module rrm_irq
  import rrm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [SLOT_W-1:0]    set_idx,
  input  logic                 clr,
  input  logic [NUM_SLOTS-1:0] mask,
  input  logic                 int_en,
  input  logic                 int_clr,
  output logic [NUM_SLOTS-1:0] flags,
  output logic                 irq_n
);

  logic [NUM_SLOTS-1:0] set_vec;

  always_comb begin
    set_vec = '0;
    if (set_en && (int'(set_idx) < NUM_SLOTS)) set_vec[set_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (clr ? '0 : flags) | set_vec;
  end

  assign irq_n = !(int_en && !int_clr && |(flags & ~mask));

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (flags & $past(flags)) == $past(flags)); // R7

endmodule

// File: rtl/rr_monitor.sv
module rr_monitor
  import rrm_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int LOOP_CYCLES = 100_000_000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_start,
  input  logic                 cfg_int_en,
  input  logic                 cfg_int_clr,
  input  logic [NUM_SLOTS-1:0] irq_mask,
  output logic                 conv_req_valid,
  input  logic                 conv_req_ready,
  output logic [SLOT_W-1:0]    conv_req_slot,
  input  logic                 conv_rsp_valid,
  output logic                 conv_rsp_ready,
  input  logic [DATA_W-1:0]    conv_rsp_data,
  input  logic                 lim_wr_en,
  input  logic [SLOT_W-1:0]    lim_wr_slot,
  input  logic [DATA_W-1:0]    lim_wr_hi,
  input  logic [DATA_W-1:0]    lim_wr_lo,
  input  logic [SLOT_W-1:0]    val_rd_slot,
  output logic [DATA_W-1:0]    val_rd_data,
  output logic [NUM_SLOTS-1:0] stat_flags,
  input  logic                 stat_clr,
  output logic                 mon_active,
  output logic                 irq_n
);

  logic run;
  logic take;
  logic viol;

  assign run = cfg_start && !cfg_int_clr;

  rrm_sequencer #(.LOOP_CYCLES(LOOP_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .req_valid (conv_req_valid),
    .req_ready (conv_req_ready),
    .req_slot  (conv_req_slot),
    .rsp_valid (conv_rsp_valid),
    .rsp_ready (conv_rsp_ready),
    .rsp_take  (take),
    .active    (mon_active)
  );

  rrm_store #(.DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .lim_we   (lim_wr_en),
    .lim_slot (lim_wr_slot),
    .lim_hi   (lim_wr_hi),
    .lim_lo   (lim_wr_lo),
    .wr_en    (take),
    .wr_slot  (conv_req_slot),
    .wr_data  (conv_rsp_data),
    .rd_slot  (val_rd_slot),
    .rd_data  (val_rd_data),
    .wr_viol  (viol)
  );

  rrm_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (take && viol),
    .set_idx (conv_req_slot),
    .clr     (stat_clr),
    .mask    (irq_mask),
    .int_en  (cfg_int_en),
    .int_clr (cfg_int_clr),
    .flags   (stat_flags),
    .irq_n   (irq_n)
  );

  AST_CLR_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_int_clr |-> irq_n); // R11

endmodule

// File: tb/rr_monitor_bench.sv
module rr_monitor_bench;
  localparam int LOOP = 20;
  localparam int NS   = 9;

  logic clk = 0, rst_n = 0;
  logic cfg_start = 0, cfg_int_en = 0, cfg_int_clr = 0;
  logic [NS-1:0] irq_mask = '0;
  logic conv_req_valid, conv_req_ready, conv_rsp_valid, conv_rsp_ready;
  logic [3:0] conv_req_slot, lim_wr_slot = '0, val_rd_slot = '0;
  logic [7:0] conv_rsp_data, lim_wr_hi = '0, lim_wr_lo = '0, val_rd_data;
  logic lim_wr_en = 0, stat_clr = 0, mon_active, irq_n;
  logic [NS-1:0] stat_flags;

  int n_checks = 0, n_err = 0;
  int exp_q[$];
  int loops_done = 0, last_req_slot = -1;
  bit measure_gap = 0;
  logic [7:0] tbl [NS];
  logic [7:0] b_hi [NS];
  logic [7:0] b_lo [NS];

  always #5 clk = ~clk;

  rr_monitor #(.DATA_W(8), .LOOP_CYCLES(LOOP)) u_rr_monitor (.*);

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
  endtask

  task automatic push_loop();
    for (int i = 0; i < NS; i++) exp_q.push_back(i);
  endtask

  task automatic set_lim(int s, logic [7:0] hi, logic [7:0] lo);
    @(negedge clk);
    lim_wr_en = 1; lim_wr_slot = 4'(s); lim_wr_hi = hi; lim_wr_lo = lo;
    b_hi[s] = hi; b_lo[s] = lo;
    @(negedge clk);
    lim_wr_en = 0;
  endtask

  function automatic bit exp_viol(int s, logic [7:0] d);
    if (s == 0) return ($signed(d) > $signed(b_hi[s])) || ($signed(d) < $signed(b_lo[s]));
    if (s < 7)  return (d > b_hi[s]) || (d < b_lo[s]);
    return d > b_hi[s];
  endfunction

  task automatic clean_tbl();
    tbl[0] = 8'hE7;
    for (int i = 1; i < 7; i++) tbl[i] = 8'd150;
    tbl[7] = 8'd130; tbl[8] = 8'd140;
  endtask

  // Converter model and scoreboard monitor
  initial begin
    int s, g, e;
    conv_req_ready = 0; conv_rsp_valid = 0; conv_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (conv_req_valid) begin
        s = int'(conv_req_slot);
        repeat (s % 3) begin
          @(negedge clk);
          chk(conv_req_valid && int'(conv_req_slot) == s, "R3", "request held under stall",
              int'(conv_req_slot), s);
        end
        conv_req_ready = 1;
        if (exp_q.size() == 0) chk(0, "R1", "unexpected request slot", s, -1);
        else begin
          e = exp_q.pop_front();
          chk(s == e, "R1", "slot order", s, e);
        end
        last_req_slot = s;
        @(negedge clk);
        conv_req_ready = 0;
        chk(conv_rsp_ready && !conv_req_valid, "R3", "waiting for one result",
            {conv_rsp_ready, conv_req_valid}, 2);
        repeat (s % 2) @(negedge clk);
        conv_rsp_valid = 1; conv_rsp_data = tbl[s];
        @(negedge clk);
        conv_rsp_valid = 0;
        val_rd_slot = 4'(s);
        #1;
        chk(val_rd_data == tbl[s], "R2", "stored result", val_rd_data, tbl[s]);
        if (s == 8) begin
          loops_done++;
          if (measure_gap) begin
            measure_gap = 0;
            g = 0;
            while (!conv_req_valid) begin g++; @(negedge clk); end
            chk(g == LOOP, "R1", "idle cycles between loops", g, LOOP);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "WATCHDOG", "run did not finish", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [NS-1:0] expf, snap;
    clean_tbl();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(irq_n == 1, "R12", "irq_n after reset", irq_n, 1);
    chk(conv_req_valid == 0, "R12", "no request after reset", conv_req_valid, 0);
    chk(mon_active == 0, "R12", "halted after reset", mon_active, 0);
    chk(stat_flags == '0, "R12", "flags after reset", stat_flags, 0);

    set_lim(0, 8'h19, 8'hD8);
    for (int i = 1; i < 7; i++) set_lim(i, 8'd200, 8'd100);
    set_lim(7, 8'd150, 8'd120);
    set_lim(8, 8'd150, 8'd120);

    // Two loops, stop requested early in the second
    measure_gap = 1;
    push_loop(); push_loop();
    @(negedge clk); cfg_int_en = 1; cfg_start = 1;
    wait (exp_q.size() <= 8);
    @(negedge clk); cfg_start = 0;
    wait (loops_done == 2);
    repeat (3) @(negedge clk);
    chk(mon_active == 0, "R9", "halted after loop finished", mon_active, 0);
    chk(conv_req_valid == 0, "R9", "no request after stop", conv_req_valid, 0);
    chk(exp_q.size() == 0, "R9", "remaining slots of loop completed", exp_q.size(), 0);
    chk(stat_flags[0] == 0, "R4", "-25 within signed limits", stat_flags[0], 0);
    chk(stat_flags == '0, "R5", "in-range loop raises no flags", stat_flags, 0);

    // Violation loop
    tbl[0] = 8'hD0; tbl[2] = 8'd210; tbl[4] = 8'd50; tbl[7] = 8'd200; tbl[8] = 8'd100;
    expf = '0;
    for (int i = 0; i < NS; i++) expf[i] = exp_viol(i, tbl[i]);
    irq_mask = '1;
    push_loop();
    @(negedge clk); cfg_start = 1;
    wait (exp_q.size() <= 8);
    @(negedge clk); cfg_start = 0;
    wait (loops_done == 3);
    repeat (2) @(negedge clk);
    chk(stat_flags[0] == 1, "R4", "-48 below signed low limit", stat_flags[0], 1);
    chk(stat_flags[2] == 1 && stat_flags[4] == 1 && stat_flags[3] == 0, "R5",
        "unsigned high/low violations", stat_flags, expf);
    chk(stat_flags[7] == 1, "R6", "fan count above limit", stat_flags[7], 1);
    chk(stat_flags[8] == 0, "R6", "fan count below low limit ignored", stat_flags[8], 0);
    chk(stat_flags == expf, "R5", "full flag vector", stat_flags, expf);
    chk(irq_n == 1, "R8", "all sources masked", irq_n, 1);

    @(negedge clk); irq_mask = ~(9'h1 << 7); #1;
    chk(irq_n == 0, "R8", "unmasked fan source asserts", irq_n, 0);
    @(negedge clk); cfg_int_en = 0; #1;
    chk(irq_n == 1, "R8", "global enable off", irq_n, 1);
    @(negedge clk); cfg_int_en = 1; cfg_int_clr = 1; #1;
    chk(irq_n == 1, "R11", "clear forces output high", irq_n, 1);
    snap = stat_flags;
    repeat (3) @(negedge clk);
    chk(stat_flags == snap, "R11", "clear leaves flags", stat_flags, snap);
    cfg_int_clr = 0; #1;
    chk(irq_n == 0, "R8", "output returns after clear released", irq_n, 0);

    // Sticky across a clean loop
    clean_tbl();
    push_loop();
    @(negedge clk); cfg_start = 1;
    wait (exp_q.size() <= 8);
    @(negedge clk); cfg_start = 0;
    wait (loops_done == 4);
    repeat (2) @(negedge clk);
    chk(stat_flags == expf, "R7", "flags sticky over clean loop", stat_flags, expf);
    stat_clr = 1;
    @(negedge clk); stat_clr = 0; #1;
    chk(stat_flags == '0, "R7", "clear pulse empties flags", stat_flags, 0);
    chk(irq_n == 1, "R7", "no interrupt after flag clear", irq_n, 1);

    // Interrupt clear halts after loop, restart at slot 0
    push_loop();
    @(negedge clk); cfg_start = 1;
    wait (exp_q.size() <= 4);
    @(negedge clk); cfg_int_clr = 1;
    wait (loops_done == 5);
    repeat (3) @(negedge clk);
    chk(mon_active == 0, "R9", "interrupt clear halts after loop", mon_active, 0);
    chk(exp_q.size() == 0, "R9", "loop completed under clear", exp_q.size(), 0);
    push_loop();
    cfg_int_clr = 0;
    wait (exp_q.size() <= 8);
    chk(last_req_slot == 0, "R10", "restart begins at slot 0", last_req_slot, 0);
    @(negedge clk); cfg_start = 0;
    wait (loops_done == 6);
    repeat (3) @(negedge clk);
    chk(mon_active == 0, "R9", "halted at end", mon_active, 0);

    summary();
    $finish;
  end
endmodule